// File: doc/BRIEF.md
# eMMC PHY Power-Up Sequencer

This block brings an eMMC I/O PHY out of reset with no software involvement. After a one-cycle `start` pulse it walks a fixed chain of operations on the PHY's 8-bit configuration registers through a simple request/acknowledge register port. Most operations are read-modify-write: the current register value is read, a set of bits is ORed in and the result is written back, so bits the sequence does not own keep their values.

Two operations are special. Partway through the chain the sequencer polls a status register until pad calibration reports completion, with a timeout counted in ticks of a free-running microsecond strobe. The last operation is a plain write that puts the PHY into legacy timing mode. When the final write is acknowledged, `done` pulses for one cycle. If calibration never completed, `error` is raised and stays high until the next start. The remaining steps are still carried out.

Top module: `phy_bringup_seq`

## Requirements
- R1: After a synchronous reset, `reg_req`, `done` and `error` are low, and no port transaction is issued until `start` is seen.
- R2: A `start` pulse while idle begins the sequence at its first step. A `start` while the sequence is running is ignored: the chain neither restarts nor repeats, and `done` pulses exactly once.
- R3: Before calibration, the sequencer reads register 0x01 and writes back the read value ORed with 0x42 (bits 6 and 1). It then reads 0x02 and writes back the read value ORed with 0x02 (bit 1). All other bits keep their read value.
- R4: It then reads register 0x03 repeatedly, one read at a time, until a read returns bit 4 set. No later step starts before that read, unless R7 applies.
- R5: After calibration, read-modify-write steps follow in this order, each writing the read value ORed with the mask: 0x06|0x03, 0x08|0x02, 0x20|0x01, 0x07|0xFF, 0x09|0xFF, 0x21|0xFF, 0x22|0x01, 0x23|0x01, 0x0F|0x07.
- R6: The last transaction is a write of 0x04 to register 0x11, with no read of 0x11 before it.
- R7: If no read of 0x03 shows bit 4 set within `TIMEOUT_US` (default 100) ticks of `us_tick` from the start of polling, the next poll read that shows bit 4 clear raises `error` and the chain continues with R5. Calibration that completes within the limit leaves `error` low.
- R8: `done` is high for exactly one cycle, two cycles after the acknowledge of the final write. `error` is cleared when a new sequence starts and otherwise holds its value.
- R9: At most one transaction is outstanding. `reg_req` stays high with stable `reg_we`, `reg_addr` and `reg_wdata` until `reg_ack`, and drops in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence (used only while idle) |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| reg_req | output | 1 | Register port request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | PHY register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| reg_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle pulse when the sequence ends |
| error | output | 1 | Calibration timed out in the last sequence |

## Verification
The checker watches the port handshake (request held with a stable payload until acknowledge, then dropped), the one-cycle width of `done` and its link to the acknowledge of the final write, the legacy-mode value on any write to 0x11, and that `error` only rises right after an acknowledged status read. The order of the chain, the preserved bits in every read-modify-write, the repeated status polling and where its timeout falls against calibration arriving early, late or never can only be shown by the bench's scenarios. The same holds for a start ignored while busy, because each depends on register contents and latencies the bench chooses.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;
  localparam int PHY_AW    = 8;
  localparam int PHY_DW    = 8;
  localparam int NUM_STEPS = 13;
  localparam int STEP_IW   = $clog2(NUM_STEPS);

  typedef logic [PHY_AW-1:0] paddr_t;
  typedef logic [PHY_DW-1:0] pdata_t;

  // kind of operation a step performs
  typedef enum logic [1:0] {
    OP_RMW  = 2'd0,  // read, OR in bits, write back
    OP_POLL = 2'd1,  // read until any of bits is set (or timeout)
    OP_WR   = 2'd2   // write bits as the value
  } op_e;

  typedef struct packed {
    op_e    op;
    paddr_t addr;
    pdata_t bits;
  } step_t;

  // Ordered power-up chain; the order is part of the behaviour.
  function automatic step_t step_at(input logic [STEP_IW-1:0] i);
    step_t s;
    case (i)
      4'd0:    s = '{OP_RMW,  8'h01, 8'h42};  // retention + power-down release
      4'd1:    s = '{OP_RMW,  8'h02, 8'h02};  // resistor trim enable
      4'd2:    s = '{OP_POLL, 8'h03, 8'h10};  // calibration done flag
      4'd3:    s = '{OP_RMW,  8'h06, 8'h03};  // cmd + strobe receivers
      4'd4:    s = '{OP_RMW,  8'h08, 8'h02};  // cmd pull-up
      4'd5:    s = '{OP_RMW,  8'h20, 8'h01};  // cmd pad power
      4'd6:    s = '{OP_RMW,  8'h07, 8'hFF};  // data receivers
      4'd7:    s = '{OP_RMW,  8'h09, 8'hFF};  // data pull-ups
      4'd8:    s = '{OP_RMW,  8'h21, 8'hFF};  // data pad power
      4'd9:    s = '{OP_RMW,  8'h22, 8'h01};  // strobe pad power
      4'd10:   s = '{OP_RMW,  8'h23, 8'h01};  // clock pad power
      4'd11:   s = '{OP_RMW,  8'h0F, 8'h07};  // clock buffer select
      default: s = '{OP_WR,   8'h11, 8'h04};  // legacy timing mode
    endcase
    return s;
  endfunction
endpackage

// File: rtl/phy_step_rom.sv
module phy_step_rom
  import phy_bringup_pkg::*;
(
  input  logic [STEP_IW-1:0] idx,
  output step_t              step,
  output logic               last
);
  localparam logic [STEP_IW-1:0] LAST_IDX = STEP_IW'(NUM_STEPS - 1);

  assign step = step_at(idx);
  assign last = (idx == LAST_IDX);
endmodule

// File: rtl/phy_xact_port.sv
module phy_xact_port
  import phy_bringup_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  input  logic   go_we,
  input  paddr_t go_addr,
  input  pdata_t go_wdata,
  output logic   req,
  output logic   we,
  output paddr_t addr,
  output pdata_t wdata,
  input  logic   ack,
  input  pdata_t rdata,
  output logic   fin,
  output pdata_t rd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
      fin   <= 1'b0;
      rd_q  <= '0;
    end else begin
      fin <= 1'b0;
      if (req) begin
        if (ack) begin
          req  <= 1'b0;
          fin  <= 1'b1;
          rd_q <= rdata;
        end
      end else if (go) begin
        req   <= 1'b1;
        we    <= go_we;
        addr  <= go_addr;
        wdata <= go_wdata;
      end
    end
  end
endmodule

// File: rtl/phy_us_timer.sv
module phy_us_timer #(
  parameter int LIMIT = 100,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (tick && cnt != LIM)
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int TIMEOUT_US = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              us_tick,
  output logic              reg_req,
  output logic              reg_we,
  output logic [PHY_AW-1:0] reg_addr,
  output logic [PHY_DW-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [PHY_DW-1:0] reg_rdata,
  output logic              done,
  output logic              error
);
  localparam int TMR_W = $clog2(TIMEOUT_US + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT} sq_e;

  sq_e               state;
  logic [STEP_IW-1:0] idx;
  logic              wr_phase;   // RMW step is in its write half
  logic              in_wr;      // outstanding transaction is a write
  pdata_t            wbuf;
  step_t             cur;
  logic              is_last;
  logic              go, go_we, fin, expired, tmr_clr;
  pdata_t            go_wdata, rd_q;

  phy_step_rom u_rom (
    .idx  (idx),
    .step (cur),
    .last (is_last)
  );

  assign go       = (state == SQ_LAUNCH);
  assign go_we    = wr_phase || (cur.op == OP_WR);
  assign go_wdata = (cur.op == OP_WR) ? cur.bits : wbuf;

  phy_xact_port u_port (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_we    (go_we),
    .go_addr  (cur.addr),
    .go_wdata (go_wdata),
    .req      (reg_req),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ack      (reg_ack),
    .rdata    (reg_rdata),
    .fin      (fin),
    .rd_q     (rd_q)
  );

  assign tmr_clr = (state == SQ_IDLE) || (cur.op != OP_POLL);

  phy_us_timer #(.LIMIT(TIMEOUT_US), .W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .tick    (us_tick),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      idx      <= '0;
      wr_phase <= 1'b0;
      in_wr    <= 1'b0;
      wbuf     <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            idx      <= '0;
            wr_phase <= 1'b0;
            error    <= 1'b0;
            state    <= SQ_LAUNCH;
          end
        end
        SQ_LAUNCH: begin
          in_wr <= go_we;
          state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (fin) begin
            if (!in_wr && cur.op == OP_RMW) begin
              wbuf     <= rd_q | cur.bits;
              wr_phase <= 1'b1;
              state    <= SQ_LAUNCH;
            end else if (!in_wr && cur.op == OP_POLL &&
                         (rd_q & cur.bits) == '0 && !expired) begin
              state <= SQ_LAUNCH;
            end else begin
              if (!in_wr && cur.op == OP_POLL && (rd_q & cur.bits) == '0)
                error <= 1'b1;
              wr_phase <= 1'b0;
              if (is_last) begin
                done  <= 1'b1;
                state <= SQ_IDLE;
              end else begin
                idx   <= idx + 1'b1;
                state <= SQ_LAUNCH;
              end
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_req,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_ack,
  input logic       done,
  input logic       error
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> reg_req);
  // R9
  req_payload_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata));
  // R9
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_ack |=> !reg_req);
  // R6
  legacy_value_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_we && reg_addr == 8'h11 |-> reg_wdata == 8'h04);
  // R8
  done_width_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(reg_req && reg_ack && reg_we && reg_addr == 8'h11, 2));
  // R7
  error_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> $past(reg_req && reg_ack && !reg_we && reg_addr == 8'h03, 2));
endmodule

bind phy_bringup_seq phy_bringup_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_req   (reg_req),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_ack   (reg_ack),
  .done      (done),
  .error     (error)
);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
  localparam int CLK_NS  = 10;
  localparam int TMO     = 100;
  localparam int TDIV    = 4;
  localparam int LOGN    = 1024;
  localparam int NEVER   = 1000000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, us_tick = 1'b0;
  logic reg_req, reg_we, reg_ack, done, error;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  phy_bringup_seq #(.TIMEOUT_US(TMO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .us_tick(us_tick),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .done(done), .error(error));

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [256];
  logic [7:0] init [256];
  logic       lg_we   [LOGN];
  logic [7:0] lg_addr [LOGN];
  logic [7:0] lg_data [LOGN];
  int         lg_cyc  [LOGN];
  int lg_n = 0;
  int cal_delay = 0;
  int first_poll = -1;
  int done_cnt = 0;

  // expected chain, from the requirements (0=rmw 1=poll 2=write)
  localparam logic [1:0] E_OP [13] = '{0,0,1,0,0,0,0,0,0,0,0,0,2};
  localparam logic [7:0] E_AD [13] = '{8'h01,8'h02,8'h03,8'h06,8'h08,8'h20,8'h07,
                                       8'h09,8'h21,8'h22,8'h23,8'h0F,8'h11};
  localparam logic [7:0] E_MK [13] = '{8'h42,8'h02,8'h10,8'h03,8'h02,8'h01,8'hFF,
                                       8'hFF,8'hFF,8'h01,8'h01,8'h07,8'h04};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // microsecond strobe
  initial forever begin
    @(negedge clk);
    us_tick = (cyc % TDIV == 0);
  end

  // done pulse counter
  always @(posedge clk) if (!rst && done) done_cnt <= done_cnt + 1;

  // register port responder with random latency
  initial begin
    int wait_left = 0;
    logic [7:0] a0;
    logic w0;
    bit seen = 0;
    reg_ack = 1'b0;
    reg_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (reg_ack) begin
        reg_ack = 1'b0;
        seen = 0;
      end else if (reg_req) begin
        if (!seen) begin
          seen = 1; a0 = reg_addr; w0 = reg_we;
        end
        if (wait_left > 0) wait_left--;
        else begin
          // R9: payload held while waiting
          chk(a0 == reg_addr && w0 == reg_we, "R9 payload", int'(reg_addr), int'(a0));
          if (reg_we) mem[reg_addr] = reg_wdata;
          else if (reg_addr == 8'h03) begin
            if (first_poll < 0) first_poll = cyc;
            if (cyc - first_poll >= cal_delay) reg_rdata = mem[3] | 8'h10;
            else reg_rdata = mem[3] & 8'hEF;
          end else reg_rdata = mem[reg_addr];
          if (lg_n < LOGN) begin
            lg_we[lg_n] = reg_we; lg_addr[lg_n] = reg_addr;
            lg_data[lg_n] = reg_we ? reg_wdata : reg_rdata; lg_cyc[lg_n] = cyc;
          end
          lg_n++;
          reg_ack = 1'b1;
          wait_left = $urandom % 4;
        end
      end
    end
  end

  task automatic run(input int delay, input bit exp_err, input bit restart_poke);
    int t0;
    int pos = 0;
    int k, pf, pl;
    int dc0;
    string tg;
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'($urandom);
      init[a] = mem[a];
    end
    cal_delay = delay; first_poll = -1; lg_n = 0;
    @(negedge clk);
    dc0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(error == 1'b0, "R8 error cleared on start", int'(error), 0);
    t0 = cyc;
    while (!done && cyc - t0 < 5000) begin
      if (restart_poke && cyc - t0 == 40) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R8 done seen", int'(done), 1);
    chk(error == exp_err, "R7 error flag", int'(error), int'(exp_err));
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(error == exp_err, "R8 error held", int'(error), int'(exp_err));
    repeat (30) @(negedge clk);
    chk(done_cnt - dc0 == 1, "R2 one done per start", done_cnt - dc0, 1);
    // compare the transaction log against the required chain
    for (int s = 0; s < 13; s++) begin
      tg = (s < 2) ? "R3" : "R5";
      if (E_OP[s] == 2'd0) begin
        chk(pos < lg_n && !lg_we[pos] && lg_addr[pos] == E_AD[s],
            {tg, " read"}, int'(lg_addr[pos]), int'(E_AD[s]));
        pos++;
        chk(pos < lg_n && lg_we[pos] && lg_addr[pos] == E_AD[s] &&
            lg_data[pos] == (init[E_AD[s]] | E_MK[s]),
            {tg, " write"}, int'(lg_data[pos]), int'(init[E_AD[s]] | E_MK[s]));
        pos++;
      end else if (E_OP[s] == 2'd1) begin
        k = 0; pf = 0; pl = 0;
        while (pos < lg_n && !lg_we[pos] && lg_addr[pos] == 8'h03) begin
          if (k == 0) pf = lg_cyc[pos];
          pl = lg_cyc[pos];
          k++; pos++;
        end
        chk(k >= 1, "R4 poll reads", k, 1);
        if (exp_err) begin
          chk(pl - pf >= (TMO - 2) * TDIV && pl - pf <= TMO * TDIV + 40,
              "R7 timeout window", pl - pf, TMO * TDIV);
        end else begin
          chk(pl - pf >= delay, "R4 polled until flag", pl - pf, delay);
        end
      end else begin
        chk(pos < lg_n && lg_we[pos] && lg_addr[pos] == 8'h11 && lg_data[pos] == 8'h04,
            "R6 legacy write", int'(lg_data[pos]), 4);
        pos++;
      end
    end
    chk(pos == lg_n, "R2 no extra transactions", lg_n, pos);
    chk(mem[8'h11] == 8'h04, "R6 mode register", int'(mem[8'h11]), 4);
  endtask

  initial begin
    void'($urandom(32'd2417));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!reg_req && !done && !error, "R1 reset outputs",
        {reg_req, done, error}, 0);
    repeat (10) @(negedge clk);
    chk(lg_n == 0, "R1 idle without start", lg_n, 0);
    run(0, 1'b0, 1'b0);
    run(120, 1'b0, 1'b0);
    run(360, 1'b0, 1'b0);          // late but within the limit
    run(NEVER, 1'b1, 1'b0);        // never calibrates
    run(40, 1'b0, 1'b1);           // start while busy, error clears
    for (int r = 0; r < 3; r++) run(int'($urandom % 300), 1'b0, 1'b0);
    run(NEVER, 1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule